// File: doc/BRIEF.md
# Parameterized Custom-Format Floating-Point Multiplier

This block multiplies two floating-point numbers held in a compact, fully parameterized format. The exponent width and fraction width are free parameters. Each word carries a two-bit class tag in front of the sign, exponent and fraction. Zero, infinity and NaN live only in that tag, so every exponent code, including all-zeros and all-ones, describes an ordinary normalized number. A normal word has the value (-1)^sign x 1.frac x 2^(exp - bias), with bias = 2^(EXP_W-1) - 1. There are no subnormals: a result too small for the format becomes zero.

Operands enter with a valid strobe, one pair per cycle if needed. The rounded product leaves exactly `LAT` cycles later with its own valid strobe. There is no back-pressure. The datapath is a single combinational evaluation step that does these things in order:
- forms the significand product;
- normalizes it by at most one place;
- rounds to nearest with ties to even;
- resolves the exponent and the class.

A `LAT`-deep register chain follows that step. The block has no state machine. Its only state is the valid bit and the result word in each pipeline slot.

Top module: `fpmul_custom`

## Requirements
- R1: A word is packed as {cls[1:0], sign, exp[EXP_W-1:0], frac[FRAC_W-1:0]} with cls in the top two bits. The cls codes are 00 zero, 01 normal, 10 infinity and 11 NaN. All exp codes 0 to 2^EXP_W-1 are legal for normal operands.
- R2: For two normal operands whose product stays in range, the output is normal. Its exp is expA + expB - bias + n, where n is 1 when the significand product is at least 2.0 and 0 otherwise. Its frac is the normalized significand rounded to FRAC_W bits.
- R3: The output sign is the XOR of the operand signs for every output class.
- R4: If either operand is NaN, or one is zero and the other infinity, the output is NaN. Otherwise, if either operand is infinity, the output is infinity. Otherwise, if either operand is zero, the output is zero.
- R5: For a normal x normal product whose final exponent exceeds 2^EXP_W-1, the output is infinity.
- R6: For a normal x normal product whose final exponent is below 0, the output is zero. No subnormal is produced.
- R7: When rounding carries out of the significand, the frac becomes 0 and the exponent grows by one. That increase alone can push the result to infinity.
- R8: Every output of class zero, infinity or NaN has its exp and frac fields all zeros.
- R9: `out_valid` rises exactly `LAT` cycles after each `in_valid`, one for one, and stays low during reset and for the first `LAT` cycles after reset.
- R10: When the discarded bits are exactly half an LSB, the result is rounded to the even frac value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 3+EXP_W+FRAC_W | First operand |
| in_b | input | 3+EXP_W+FRAC_W | Second operand |
| out_valid | output | 1 | Product present this cycle |
| out_res | output | 3+EXP_W+FRAC_W | Product word |

## Verification
Rounding and exponent range checking can act on the same product. A round-up carry can move a product from the largest exponent into infinity (R7 with R5), or lift an exponent of -1 back to 0 (R7 with R6). The bench provokes both by sweeping every pair of normal operands in a 4-bit-exponent, 3-bit-fraction configuration. That sweep reaches every carry-at-boundary case. Each output is compared with a value derived from exact integer products of the significands, in which the carry is applied before the range test.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'b00,
        CLS_NORM = 2'b01,
        CLS_INF  = 2'b10,
        CLS_NAN  = 2'b11
    } cls_t;

endpackage

// File: rtl/fpm_sig_round.sv
module fpm_sig_round #(
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W-1:0] frac_a,
    input  logic [FRAC_W-1:0] frac_b,
    output logic [FRAC_W-1:0] frac_out,
    output logic              norm_up,
    output logic              rnd_carry
);
    localparam int SW = FRAC_W + 1;
    localparam int PW = 2 * SW;

    logic [PW-1:0]     prod;
    logic [PW-2:0]     aligned;
    logic [FRAC_W-1:0] kept;
    logic              guard_bit;
    logic              sticky_bit;
    logic              bump;
    logic [FRAC_W:0]   rounded;

    always_comb begin
        prod       = {1'b1, frac_a} * {1'b1, frac_b};
        norm_up    = prod[PW-1];
        aligned    = norm_up ? prod[PW-2:0] : {prod[PW-3:0], 1'b0};
        kept       = aligned[PW-2 -: FRAC_W];
        guard_bit  = aligned[PW-2-FRAC_W];
        sticky_bit = |aligned[PW-3-FRAC_W:0];
        bump       = guard_bit & (sticky_bit | kept[0]);
        rounded    = {1'b0, kept} + {{FRAC_W{1'b0}}, bump};
        rnd_carry  = rounded[FRAC_W];
        frac_out   = rounded[FRAC_W-1:0];
    end

endmodule

// File: rtl/fpm_cls_resolve.sv
module fpm_cls_resolve
    import fpm_pkg::*;
(
    input  logic [1:0] cls_a,
    input  logic [1:0] cls_b,
    input  logic       too_big,
    input  logic       too_small,
    output logic [1:0] cls_out
);
    logic any_nan, any_inf, any_zero;

    always_comb begin
        any_nan  = (cls_a == CLS_NAN)  || (cls_b == CLS_NAN);
        any_inf  = (cls_a == CLS_INF)  || (cls_b == CLS_INF);
        any_zero = (cls_a == CLS_ZERO) || (cls_b == CLS_ZERO);
        if (any_nan || (any_inf && any_zero)) cls_out = CLS_NAN;
        else if (any_inf)                     cls_out = CLS_INF;
        else if (any_zero)                    cls_out = CLS_ZERO;
        else if (too_big)                     cls_out = CLS_INF;
        else if (too_small)                   cls_out = CLS_ZERO;
        else                                  cls_out = CLS_NORM;
    end

endmodule

// File: rtl/fpm_pipe.sv
module fpm_pipe #(
    parameter int W   = 34,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);
    logic         vq [LAT];
    logic [W-1:0] dq [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) vq[i] <= 1'b0;
        end else begin
            vq[0] <= in_v;
            for (int i = 1; i < LAT; i++) vq[i] <= vq[i-1];
        end
    end

    always_ff @(posedge clk) begin
        dq[0] <= in_d;
        for (int i = 1; i < LAT; i++) dq[i] <= dq[i-1];
    end

    assign out_v = vq[LAT-1];
    assign out_d = dq[LAT-1];

endmodule

// File: rtl/fpmul_custom.sv
module fpmul_custom
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int LAT    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [3+EXP_W+FRAC_W-1:0]   in_a,
    input  logic [3+EXP_W+FRAC_W-1:0]   in_b,
    output logic                        out_valid,
    output logic [3+EXP_W+FRAC_W-1:0]   out_res
);
    localparam int W    = 3 + EXP_W + FRAC_W;
    localparam int XW   = EXP_W + 3;
    localparam int BIAS = 2 ** (EXP_W - 1) - 1;
    localparam int EMAX = 2 ** EXP_W - 1;

    logic [1:0]        cls_a, cls_b, cls_r;
    logic              sgn_r;
    logic [EXP_W-1:0]  exp_a, exp_b;
    logic [FRAC_W-1:0] frac_a, frac_b, frac_r;
    logic              norm_up, rnd_carry;
    logic signed [XW-1:0] exp_full;
    logic              too_big, too_small;
    logic [W-1:0]      word_r;

    assign {cls_a, exp_a, frac_a} = {in_a[W-1 -: 2], in_a[EXP_W+FRAC_W-1:0]};
    assign {cls_b, exp_b, frac_b} = {in_b[W-1 -: 2], in_b[EXP_W+FRAC_W-1:0]};
    assign sgn_r = in_a[W-3] ^ in_b[W-3];

    fpm_sig_round #(.FRAC_W(FRAC_W)) u_sig (
        .frac_a   (frac_a),
        .frac_b   (frac_b),
        .frac_out (frac_r),
        .norm_up  (norm_up),
        .rnd_carry(rnd_carry)
    );

    always_comb begin
        exp_full  = $signed({3'b000, exp_a}) + $signed({3'b000, exp_b})
                  - $signed(XW'(BIAS))
                  + $signed({{(XW-1){1'b0}}, norm_up})
                  + $signed({{(XW-1){1'b0}}, rnd_carry});
        too_big   = exp_full > $signed(XW'(EMAX));
        too_small = exp_full[XW-1];
    end

    fpm_cls_resolve u_cls (
        .cls_a    (cls_a),
        .cls_b    (cls_b),
        .too_big  (too_big),
        .too_small(too_small),
        .cls_out  (cls_r)
    );

    always_comb begin
        if (cls_r == CLS_NORM)
            word_r = {cls_r, sgn_r, exp_full[EXP_W-1:0], frac_r};
        else
            word_r = {cls_r, sgn_r, {(EXP_W+FRAC_W){1'b0}}};
    end

    fpm_pipe #(.W(W), .LAT(LAT)) u_pipe (
        .clk  (clk),
        .rst_n(rst_n),
        .in_v (in_valid),
        .in_d (word_r),
        .out_v(out_valid),
        .out_d(out_res)
    );

endmodule

// File: rtl/fpmul_custom_chk.sv
module fpmul_custom_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int LAT    = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [2:0]                a_hdr,
    input logic [2:0]                b_hdr,
    input logic                      out_valid,
    input logic [3+EXP_W+FRAC_W-1:0] out_res
);
    localparam int W = 3 + EXP_W + FRAC_W;

    logic       vq [LAT];
    logic [2:0] aq [LAT];
    logic [2:0] bq [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                vq[i] <= 1'b0;
                aq[i] <= 3'b000;
                bq[i] <= 3'b000;
            end
        end else begin
            vq[0] <= in_valid;
            aq[0] <= a_hdr;
            bq[0] <= b_hdr;
            for (int i = 1; i < LAT; i++) begin
                vq[i] <= vq[i-1];
                aq[i] <= aq[i-1];
                bq[i] <= bq[i-1];
            end
        end
    end

    logic [2:0] ah, bh;
    logic [1:0] out_cls;
    assign ah      = aq[LAT-1];
    assign bh      = bq[LAT-1];
    assign out_cls = out_res[W-1 -: 2];

    p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vq[LAT-1]);

    p_sign_xor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_res[W-3] == (ah[0] ^ bh[0]));

    p_nan_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (ah[2:1] == 2'b11 || bh[2:1] == 2'b11)) |-> out_cls == 2'b11);

    p_zero_inf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ((ah[2:1] == 2'b00 && bh[2:1] == 2'b10) ||
                       (ah[2:1] == 2'b10 && bh[2:1] == 2'b00))) |-> out_cls == 2'b11);

    p_clear_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cls != 2'b01) |-> out_res[EXP_W+FRAC_W-1:0] == '0);

endmodule

bind fpmul_custom fpmul_custom_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .LAT(LAT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .a_hdr    (in_a[W-1 -: 3]),
    .b_hdr    (in_b[W-1 -: 3]),
    .out_valid(out_valid),
    .out_res  (out_res)
);

// File: tb/fpmul_custom_bench.sv
module fpmul_custom_bench;
    localparam int EW  = 4;
    localparam int FW  = 3;
    localparam int LAT = 2;
    localparam int W   = 3 + EW + FW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic [W-1:0] out_res;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [W-1:0] q_word [16];
    logic         q_sign [16];
    string        q_tag  [16];
    int wp = 0, rp = 0, cnt = 0;

    always #5 clk = ~clk;

    fpmul_custom #(.EXP_W(EW), .FRAC_W(FW), .LAT(LAT)) u_fpmul_custom (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_res(out_res)
    );

    // Word layout per R1: {cls, sign, exp, frac}; bias 7, exp max 15.
    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           output string tag);
        int ca, cb, p, n, sh, q, r, half, c, e;
        logic s;
        ca = int'(a[W-1 -: 2]);
        cb = int'(b[W-1 -: 2]);
        s  = a[W-3] ^ b[W-3];
        if (ca == 3 || cb == 3 || (ca == 0 && cb == 2) || (ca == 2 && cb == 0)) begin
            tag = "R4 R8"; return {2'b11, s, 7'd0};
        end
        if (ca == 2 || cb == 2) begin tag = "R4 R8"; return {2'b10, s, 7'd0}; end
        if (ca == 0 || cb == 0) begin tag = "R4 R8"; return {2'b00, s, 7'd0}; end
        p    = (8 + int'(a[2:0])) * (8 + int'(b[2:0]));
        n    = (p >= 128) ? 1 : 0;
        sh   = 3 + n;
        q    = p >> sh;
        r    = p % (1 << sh);
        half = 1 << (sh - 1);
        if (r > half || (r == half && (q % 2) == 1)) q++;
        c = 0;
        if (q == 16) begin q = 8; c = 1; end
        e = int'(a[6:3]) + int'(b[6:3]) - 7 + n + c;
        if (e > 15) begin
            tag = (c == 1 && e == 16) ? "R7 R5" : "R5";
            return {2'b10, s, 7'd0};
        end
        if (e < 0) begin tag = "R6"; return {2'b00, s, 7'd0}; end
        if (r == half)  tag = "R10";
        else if (c == 1) tag = "R7";
        else            tag = "R1 R2";
        return {2'b01, s, 4'(e), 3'(q)};
    endfunction

    task automatic check_out();
        if (out_valid) begin
            if (cnt == 0) begin
                checks++; errors++;
                $display("FAIL R9 unexpected out_valid: actual 1 expected 0");
            end else begin
                checks++;
                if (out_res !== q_word[rp]) begin
                    errors++;
                    $display("FAIL %s word: actual %h expected %h", q_tag[rp], out_res, q_word[rp]);
                end
                checks++;
                if (out_res[W-3] !== q_sign[rp]) begin
                    errors++;
                    $display("FAIL R3 sign: actual %b expected %b", out_res[W-3], q_sign[rp]);
                end
                rp = (rp + 1) % 16; cnt--;
            end
        end
    endtask

    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
        string t;
        @(negedge clk);
        check_out();
        in_valid = v; in_a = a; in_b = b;
        if (v) begin
            q_word[wp] = model(a, b, t);
            q_tag[wp]  = t;
            q_sign[wp] = a[W-3] ^ b[W-3];
            wp = (wp + 1) % 16; cnt++;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R9 valid in reset: actual %b expected 0", out_valid);
            end
        end
        rst_n = 1'b1;
        // R9: a pair presented at once must surface exactly LAT cycles later
        step(1'b1, {2'b01, 8'h38}, {2'b01, 8'h38});
        for (int k = 0; k < LAT; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            checks++;
            if (out_valid !== ((k == LAT - 1) ? 1'b1 : 1'b0)) begin
                errors++;
                $display("FAIL R9 latency at %0d: actual %b", k, out_valid);
            end
            if (k == LAT - 1) check_out();
        end
        // R2 R5 R6 R7 R10: every normal x normal pair, with idle gaps
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                step(1'b1, {2'b01, 8'(a)}, {2'b01, 8'(b)});
                if (((a + b) % 13) == 0) step(1'b0, '0, '0);
            end
        end
        // R4 R8: all class pairs with nonzero exp/frac fields
        for (int ca = 0; ca < 4; ca++)
            for (int cb = 0; cb < 4; cb++)
                for (int k = 0; k < 16; k++)
                    step(1'b1, {2'(ca), 1'(k), 4'(k * 3), 3'(k + 1)},
                               {2'(cb), 1'(k >> 1), 4'(15 - k), 3'(k * 5)});
        for (int k = 0; k < LAT + 3; k++) step(1'b0, '0, '0);
        checks++;
        if (cnt != 0) begin
            errors++;
            $display("FAIL R9 missing outputs: actual %0d pending expected 0", cnt);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule